// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits in front of a host bridge and turns processor accesses into configuration requests. The host reaches it through two windows of 4 KiB each, both little-endian, selected by one pin. The first window holds a 32-bit address register that software loads with the target of the next configuration access. A read or write through the second window builds a canonical configuration address from that register and the low bits of the window offset. It then issues exactly one request on a downstream request/response port and returns the response data to the host.

The address register may be loaded in any of three formats, and each is converted to one canonical layout: register number in bits [7:0], function in [10:8], device in [15:11]. In one format the device is not given as a number but as a one-hot select line in bits [31:11]. When no select line is set, the access is completed locally as a master abort.

The block also folds the four interrupt pins of every device on the bus onto four level-sensitive controller lines. Line 0 through line 3 feed interrupt controller inputs 27, 28, 29 and 30 (0x1B to 0x1E), in that order.

Top module: `pcicfg_xlate`

## Requirements
- R1: The address register resets to zero and reads back exactly what was written. A window-0 write updates only the byte lanes selected by its size and offset. Size 0 selects the byte at `h_off[1:0]`, size 1 selects the halfword at `h_off[1]`, and size 2 selects all four bytes. Write data is lane-aligned, with byte k in bits [8k+7:8k].
- R2: When address register bit 31 is set, the downstream address is the register value ORed with `h_off[1:0]`.
- R3: When bit 31 is clear and bit 0 is set, the downstream address is the register with bits [2:0] replaced by `h_off[2:0]`.
- R4: When bits 31 and 0 are both clear, the downstream address is built as follows. Device (bits [15:11]) is the bit position of the lowest set bit among register bits [31:11], with a value from 11 to 31. Function (bits [10:8]) is register bits [10:8]. Bits [7:3] are register bits [7:3], and bits [2:0] are `h_off[2:0]`. Bits [31:16] are zero.
- R5: In the R4 format with register bits [31:11] all zero, no downstream request is made. A read returns 0xFFFFFFFF and a write is dropped. The host sees `h_ready` one cycle after the access is offered.
- R6: A window-1 access issues exactly one downstream request. `dn_valid` and its fields stay stable until `dn_ready`. `h_ready` rises one cycle after `dn_rvalid`, so with no downstream stall it rises three cycles after the access is offered.
- R7: `dn_write`, `dn_size` and `dn_wdata` carry the host's write flag, size code and data unchanged. Offset bits above those named in R2 and R3 have no effect on the address.
- R8: Each device is numbered `FIRST_SLOT` plus its index. Pin p of device d (bit 4d+p of `dev_irq`, with p=0 being the first pin) drives `irq_line[(FIRST_SLOT+d+p) mod 4]`.
- R9: An interrupt line stays asserted while any pin mapped to it is asserted, and falls only when all of those pins are low.
- R10: Window-1 accesses never change the address register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Host access offered; hold with its fields until h_ready |
| h_ready | output | 1 | Access completes in this cycle; h_rdata valid for reads |
| h_win | input | 1 | 0 = address-register window, 1 = data window |
| h_write | input | 1 | 1 = write, 0 = read |
| h_off | input | 12 | Byte offset within the 4 KiB window |
| h_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| h_wdata | input | 32 | Lane-aligned write data |
| h_rdata | output | 32 | Read data |
| dn_valid | output | 1 | Configuration request offered |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_write | output | 1 | Request is a write |
| dn_addr | output | 32 | Canonical configuration address |
| dn_size | output | 2 | Size code, same encoding as h_size |
| dn_wdata | output | 32 | Write data |
| dn_rvalid | input | 1 | Downstream completion, one cycle pulse |
| dn_rdata | input | 32 | Completion read data |
| dev_irq | input | 16 | Interrupt pins, 4 per device |
| irq_line | output | 4 | Level interrupt lines to the controller |

## Verification
Window-0 accesses complete in the same cycle they are offered. A data-window access with no downstream stall completes three cycles after it is offered, and one more cycle for each cycle `dn_ready` is held low. An aborted access completes one cycle after it is offered. The interrupt lines follow the pins in the same cycle. The bench drives on the falling edge, samples after a short settle, and counts the falling edges until `h_ready` appears. It compares that count against these numbers for every access, so an extra or missing register stage is reported as well as a wrong value.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
  localparam int DW     = 32;
  localparam int NBYTES = DW / 8;
  localparam int SLOT_W = 5;

  typedef enum logic [1:0] {
    FMT_RAW = 2'd0,
    FMT_T1  = 2'd1,
    FMT_T0  = 2'd2
  } fmt_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2,
    S_DONE = 2'd3
  } acc_state_e;

  function automatic logic [NBYTES-1:0] lane_mask(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      2'd0:    return 4'b0001 << off;
      2'd1:    return off[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/pcicfg_areg.sv
module pcicfg_areg
  import pcicfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NBYTES-1:0] be,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     q
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        q[8*b +: 8] <= '0;
      else if (wr_en && be[b])
        q[8*b +: 8] <= wdata[8*b +: 8];
    end
  end

  AST_AREG_RST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> q == '0); // R1
endmodule

// File: rtl/pcicfg_conv.sv
module pcicfg_conv
  import pcicfg_pkg::*;
#(
  parameter int IDSEL_LO = 11
) (
  input  logic [DW-1:0] cfg_reg,
  input  logic [2:0]    off,
  output logic [DW-1:0] addr,
  output fmt_e          fmt,
  output logic          abort
);
  logic              found;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    found = 1'b0;
    slot  = '0;
    for (int i = DW - 1; i >= IDSEL_LO; i--) begin
      if (cfg_reg[i]) begin
        found = 1'b1;
        slot  = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    if (cfg_reg[DW-1])   fmt = FMT_RAW;
    else if (cfg_reg[0]) fmt = FMT_T1;
    else                 fmt = FMT_T0;
  end

  always_comb begin
    case (fmt)
      FMT_RAW: addr = cfg_reg | {{(DW-2){1'b0}}, off[1:0]};
      FMT_T1:  addr = {cfg_reg[DW-1:3], off};
      default: addr = {{(DW-16){1'b0}}, slot, cfg_reg[10:8], cfg_reg[7:3], off};
    endcase
  end

  assign abort = (fmt == FMT_T0) && !found;
endmodule

// File: rtl/pcicfg_irq_swz.sv
module pcicfg_irq_swz #(
  parameter int NUM_DEV    = 4,
  parameter int PINS       = 4,
  parameter int LINES      = 4,
  parameter int FIRST_SLOT = 12
) (
  input  logic [NUM_DEV*PINS-1:0] dev_irq,
  output logic [LINES-1:0]        irq_line
);
  always_comb begin
    irq_line = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      for (int p = 0; p < PINS; p++) begin
        if (dev_irq[d*PINS+p])
          irq_line[(FIRST_SLOT + d + p) % LINES] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcicfg_xlate.sv
module pcicfg_xlate
  import pcicfg_pkg::*;
#(
  parameter int OFF_W      = 12,
  parameter int NUM_DEV    = 4,
  parameter int FIRST_SLOT = 12,
  parameter int IDSEL_LO   = 11,
  localparam int PINS      = 4,
  localparam int LINES     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    h_valid,
  output logic                    h_ready,
  input  logic                    h_win,
  input  logic                    h_write,
  input  logic [OFF_W-1:0]        h_off,
  input  logic [1:0]              h_size,
  input  logic [DW-1:0]           h_wdata,
  output logic [DW-1:0]           h_rdata,
  output logic                    dn_valid,
  input  logic                    dn_ready,
  output logic                    dn_write,
  output logic [DW-1:0]           dn_addr,
  output logic [1:0]              dn_size,
  output logic [DW-1:0]           dn_wdata,
  input  logic                    dn_rvalid,
  input  logic [DW-1:0]           dn_rdata,
  input  logic [NUM_DEV*PINS-1:0] dev_irq,
  output logic [LINES-1:0]        irq_line
);
  acc_state_e    state;
  logic [DW-1:0] cfg_reg;
  logic [DW-1:0] conv_addr;
  fmt_e          conv_fmt;
  logic          conv_abort;
  logic [DW-1:0] rdata_q;
  logic          acc_reg, acc_data;

  assign acc_reg  = h_valid && !h_win && (state == S_IDLE);
  assign acc_data = h_valid &&  h_win && (state == S_IDLE);

  pcicfg_areg u_areg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (acc_reg && h_write),
    .be    (lane_mask(h_size, h_off[1:0])),
    .wdata (h_wdata),
    .q     (cfg_reg)
  );

  pcicfg_conv #(.IDSEL_LO(IDSEL_LO)) u_conv (
    .cfg_reg (cfg_reg),
    .off     (h_off[2:0]),
    .addr    (conv_addr),
    .fmt     (conv_fmt),
    .abort   (conv_abort)
  );

  pcicfg_irq_swz #(
    .NUM_DEV    (NUM_DEV),
    .PINS       (PINS),
    .LINES      (LINES),
    .FIRST_SLOT (FIRST_SLOT)
  ) u_swz (
    .dev_irq  (dev_irq),
    .irq_line (irq_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      dn_addr  <= '0;
      dn_write <= 1'b0;
      dn_size  <= '0;
      dn_wdata <= '0;
      rdata_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (acc_data) begin
          dn_addr  <= conv_addr;
          dn_write <= h_write;
          dn_size  <= h_size;
          dn_wdata <= h_wdata;
          if (conv_abort) begin
            rdata_q <= '1;
            state   <= S_DONE;
          end else begin
            state <= S_REQ;
          end
        end
        S_REQ:  if (dn_ready) state <= S_WAIT;
        S_WAIT: if (dn_rvalid) begin
          rdata_q <= dn_rdata;
          state   <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign dn_valid = (state == S_REQ);
  assign h_ready  = acc_reg || (state == S_DONE);

  always_comb begin
    if (acc_reg)                h_rdata = cfg_reg;
    else if (state == S_DONE)   h_rdata = rdata_q;
    else                        h_rdata = '0;
  end

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    h_ready |-> h_valid); // R6
  AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_addr) && $stable(dn_write) && $stable(dn_wdata)); // R6
  AST_ABORT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    acc_data && conv_abort |=> !dn_valid && h_ready); // R5
  AST_T0_SLOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_fmt == FMT_T0) && !conv_abort |-> cfg_reg[conv_addr[15:11]] && conv_addr[15:11] >= 5'(IDSEL_LO)); // R4
  AST_REG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_IDLE |=> $stable(cfg_reg)); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dev_irq == '0 |-> irq_line == '0); // R8
  AST_IRQ_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_line) <= $countones(dev_irq)); // R9
endmodule

// File: tb/pcicfg_xlate_bench.sv
module pcicfg_xlate_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RD_XOR = 32'h5A5A_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_valid = 1'b0, h_win = 1'b0, h_write = 1'b0;
  logic [11:0] h_off = '0;
  logic [1:0]  h_size = '0;
  logic [31:0] h_wdata = '0;
  logic        h_ready;
  logic [31:0] h_rdata;
  logic        dn_valid, dn_write;
  logic [31:0] dn_addr, dn_wdata;
  logic [1:0]  dn_size;
  logic        dn_ready = 1'b0, dn_rvalid = 1'b0;
  logic [31:0] dn_rdata = '0;
  logic [15:0] dev_irq = '0;
  logic [3:0]  irq_line;

  int total = 0, bad = 0, nreq = 0, stall = 0;
  logic        resp_pend = 1'b0;
  logic [31:0] cap_addr = '0, cap_wdata = '0;
  logic        cap_write = 1'b0;
  logic [1:0]  cap_size = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcicfg_xlate u_pcicfg_xlate (
    .clk(clk), .rst_n(rst_n),
    .h_valid(h_valid), .h_ready(h_ready), .h_win(h_win), .h_write(h_write),
    .h_off(h_off), .h_size(h_size), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_write(dn_write), .dn_addr(dn_addr),
    .dn_size(dn_size), .dn_wdata(dn_wdata), .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata),
    .dev_irq(dev_irq), .irq_line(irq_line)
  );

  // downstream responder, acts on falling edges
  always @(negedge clk) begin
    dn_rvalid = resp_pend;
    if (resp_pend) dn_rdata = cap_addr ^ RD_XOR;
    resp_pend = 1'b0;
    if (dn_valid) begin
      if (stall > 0) begin
        dn_ready = 1'b0;
        stall--;
      end else begin
        dn_ready  = 1'b1;
        cap_addr  = dn_addr;
        cap_write = dn_write;
        cap_size  = dn_size;
        cap_wdata = dn_wdata;
        resp_pend = 1'b1;
        nreq++;
      end
    end else begin
      dn_ready = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic host(input logic win, input logic wr, input logic [11:0] off,
                      input logic [1:0] sz, input logic [31:0] wd,
                      output logic [31:0] rd, output int cyc);
    @(negedge clk);
    h_valid = 1'b1; h_win = win; h_write = wr; h_off = off; h_size = sz; h_wdata = wd;
    cyc = 0;
    #1;
    while (!h_ready && cyc < 100) begin
      @(negedge clk); #1;
      cyc++;
    end
    rd = h_rdata;
    @(posedge clk); #1;
    h_valid = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] reg_v;
    logic [11:0] off;
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic [31:0] exp_addr;
    logic        abort;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{32'h8000_1234, 12'hFF3, 1'b0, 2'd2, 32'h0,           32'h8000_1237, 1'b0}, // R2
    '{32'h8000_0000, 12'h006, 1'b1, 2'd1, 32'h0000_BEEF,   32'h8000_0002, 1'b0}, // R2
    '{32'h0012_3455, 12'h80A, 1'b0, 2'd0, 32'h0,           32'h0012_3452, 1'b0}, // R3
    '{32'h0000_0B40, 12'h001, 1'b0, 2'd2, 32'h0,           32'h0000_5B41, 1'b0}, // R4
    '{32'h0030_05FE, 12'h007, 1'b1, 2'd2, 32'hCAFE_F00D,   32'h0000_A5FF, 1'b0}, // R4
    '{32'h4000_0010, 12'hC00, 1'b0, 2'd0, 32'h0,           32'h0000_F010, 1'b0}, // R4
    '{32'h0000_0700, 12'h003, 1'b0, 2'd2, 32'h0,           32'h0,         1'b1}, // R5
    '{32'h0000_0004, 12'h000, 1'b1, 2'd2, 32'h1111_2222,   32'h0,         1'b1}  // R5
  };

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cyc, n0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 reset dn_valid", {31'b0, dn_valid}, 32'h0);
    check("R6 reset h_ready", {31'b0, h_ready}, 32'h0);
    host(1'b0, 1'b0, 12'h0, 2'd2, 32'h0, rd, cyc);
    check("R1 reset register", rd, 32'h0);
    check("R1 reg window latency", cyc, 0);

    // stimulus table
    foreach (TBL[i]) begin
      vec_t v = TBL[i];
      host(1'b0, 1'b1, 12'h0, 2'd2, v.reg_v, rd, cyc);
      n0 = nreq;
      host(1'b1, v.wr, v.off, v.sz, v.wd, rd, cyc);
      if (v.abort) begin
        check("R5 no request", nreq - n0, 0);
        check("R5 abort latency", cyc, 1);
        if (!v.wr) check("R5 abort read ones", rd, 32'hFFFF_FFFF);
      end else begin
        check("R6 one request", nreq - n0, 1);
        check("R6 access latency", cyc, 3);
        check("R2 R3 R4 address", cap_addr, v.exp_addr);
        check("R7 write flag", {31'b0, cap_write}, {31'b0, v.wr});
        check("R7 size", {30'b0, cap_size}, {30'b0, v.sz});
        if (v.wr) check("R7 write data", cap_wdata, v.wd);
        else      check("R6 read data", rd, v.exp_addr ^ RD_XOR);
      end
      host(1'b0, 1'b0, 12'h0, 2'd2, 32'h0, rd, cyc);
      check("R10 register kept", rd, v.reg_v);
    end

    // partial writes of the address register
    host(1'b0, 1'b1, 12'h0, 2'd2, 32'h1122_3344, rd, cyc);
    host(1'b0, 1'b1, 12'h1, 2'd0, 32'h0000_AB00, rd, cyc);
    host(1'b0, 1'b0, 12'h0, 2'd2, 32'h0, rd, cyc);
    check("R1 byte lane write", rd, 32'h1122_AB44);
    host(1'b0, 1'b1, 12'h2, 2'd1, 32'hCDEF_0000, rd, cyc);
    host(1'b0, 1'b0, 12'h0, 2'd2, 32'h0, rd, cyc);
    check("R1 halfword lane write", rd, 32'hCDEF_AB44);

    // downstream back-pressure
    host(1'b0, 1'b1, 12'h0, 2'd2, 32'h0012_3455, rd, cyc);
    stall = 3;
    n0 = nreq;
    host(1'b1, 1'b0, 12'h004, 2'd2, 32'h0, rd, cyc);
    check("R6 stalled latency", cyc, 6);
    check("R6 stalled one request", nreq - n0, 1);
    check("R3 stalled address", cap_addr, 32'h0012_3454);
    check("R6 stalled read data", rd, 32'h0012_3454 ^ RD_XOR);

    // interrupt swizzle, FIRST_SLOT = 12
    @(negedge clk);
    dev_irq = 16'h0001; #1;             // dev0 pin0 -> 0
    check("R8 dev0 pin0", {28'b0, irq_line}, 32'h1);
    dev_irq = 16'h0040; #1;             // dev1 pin2 -> 3
    check("R8 dev1 pin2", {28'b0, irq_line}, 32'h8);
    dev_irq = 16'h8000; #1;             // dev3 pin3 -> 2
    check("R8 dev3 pin3", {28'b0, irq_line}, 32'h4);
    dev_irq = 16'h1200; #1;             // dev2 pin1 and dev3 pin0 -> 3
    check("R9 shared line", {28'b0, irq_line}, 32'h8);
    dev_irq = 16'h1000; #1;
    check("R9 line held by other pin", {28'b0, irq_line}, 32'h8);
    dev_irq = 16'h0000; #1;
    check("R9 line released", {28'b0, irq_line}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule